// File: doc/BRIEF.md
# SPI Master with Byte Queues and Receive Back-Pressure

This block is a register-mapped SPI master for up to four targets. Software fills a 32-byte transmit queue and loads a character count. It then sets a start bit together with a select mask. The block drives the select lines low and shifts each queued byte out MSB first, in mode 0, at a quarter of the system clock. Each returned byte goes into a 32-byte receive queue. The transaction ends when the count reaches zero, and a done flag is set. A hold bit decides whether the select lines stay low after the last byte.

While a transaction runs, no new byte begins when the receive queue is enabled and full. Reading one byte from the receive queue lets the next transfer begin. Bytes written to the transmit queue during a transaction are sent in turn. When exactly one select line is driven, the MISO byte is kept. When several are driven, the transfer is a broadcast and MISO is discarded. When none is driven, the value 0xFF is stored in place of a response.

The register bus is a plain single-cycle port. A write takes effect at the clock edge where `reg_wr` is high. Read data is combinational from `reg_addr` while `reg_rd` is high. A read of the data register pops the receive queue at that edge. There is no back-pressure on the bus: every access completes in one cycle. Flow control is carried by the queue counts and flags described below.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset all `ss_n` lines are high, `sclk`, `mosi` and `irq` are low, and the flag (0x10), status (0x18) and queue control (0x0C) registers read zero.
- R2: Every byte is framed in mode 0. Each SCLK period lasts four clock cycles with two low and two high. Data is sent MSB first, and MOSI is stable while SCLK is high. MISO is sampled on the rising edge.
- R3: Writing control (0x04) with bit 0 (enable) and bit 1 (start) set, while the count (0x08, bits 15:0) holds N>0, transfers exactly N bytes. The count then reads 0, the transaction ends, and done (flag bit 0) is set.
- R4: Bytes written to the data register (0x00) go out in write order. This includes bytes queued before start and bytes written during the transaction.
- R5: With exactly one bit set in the select mask (control bits 7:4), each byte received on MISO is stored in the receive queue and read back in order from 0x00.
- R6: With two or more mask bits set, nothing is stored in the receive queue. With no mask bit set, one 0xFF is stored per byte.
- R7: While the receive queue is enabled (0x0C bit 22) and full, no new byte starts and SCLK stays low. The receive-full flag (bit 4) is set. Each read from the queue lets one more byte go.
- R8: A data write while the transmit queue is enabled (0x0C bit 6) and holds 32 bytes drops the byte and sets the TX-overrun flag (bit 1). Writing 1 to 0x0C bit 7 empties the transmit queue. The transmit count is read at 0x0C bits 13:8, and the receive count at bits 29:24.
- R9: Start drives low exactly the masked lines and releases lines outside the mask. At the end of a transaction, the lines are released if hold (control bit 2) is 0 and kept low if it is 1.
- R10: Writing control with bit 0 clear releases all select lines at the next edge and stops any transfer in progress.
- R11: A data read with the receive queue disabled returns 0 and leaves the queue unchanged. A data read with the queue enabled and empty returns 0 and sets the underrun flag (bit 3).
- R12: `irq` is the OR of the flags ANDed with the enable mask (0x14). Writing 1 to a flag bit at 0x10 clears it.
- R13: Start with a count of 0 sets done at once and produces no SCLK pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe; pops the receive queue when the data register is addressed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Interrupt request, level |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 4 | Active-low target selects |

## Verification
Four properties are checked on every cycle. Disabling releases all selects at once. MOSI holds still through each SCLK high phase. A full, enabled receive queue keeps the shifter from starting. A write into a full transmit queue always raises TX overrun. In addition, the count is never zero while a transaction is active. Other behaviour only shows in the bench scenarios: byte order and content on both lines, the choice between the single-target, broadcast and 0xFF paths, and the pace of a stalled transfer as reads free room. The same holds for the select lines kept or released by the hold bit, and for reads that have no effect while the receive queue is off.

// File: rtl/spi_fifo_pkg.sv
`timescale 1ns/1ps
package spi_fifo_pkg;
  localparam int BUS_AW = 8;

  // register offsets
  localparam logic [BUS_AW-1:0] OFS_DATA  = 8'h00;
  localparam logic [BUS_AW-1:0] OFS_CTRL  = 8'h04;
  localparam logic [BUS_AW-1:0] OFS_COUNT = 8'h08;
  localparam logic [BUS_AW-1:0] OFS_FIFO  = 8'h0C;
  localparam logic [BUS_AW-1:0] OFS_FLAGS = 8'h10;
  localparam logic [BUS_AW-1:0] OFS_IEN   = 8'h14;
  localparam logic [BUS_AW-1:0] OFS_STAT  = 8'h18;

  // control bits
  localparam int CB_EN    = 0;
  localparam int CB_START = 1;
  localparam int CB_HOLD  = 2;
  localparam int CB_MASK  = 4;

  // queue control bits
  localparam int FB_TXEN  = 6;
  localparam int FB_TXCLR = 7;
  localparam int FB_TXCNT = 8;
  localparam int FB_RXEN  = 22;
  localparam int FB_RXCLR = 23;
  localparam int FB_RXCNT = 24;

  // flag bits
  localparam int FL_DONE   = 0;
  localparam int FL_TXOVR  = 1;
  localparam int FL_RXOVR  = 2;
  localparam int FL_RXUND  = 3;
  localparam int FL_RXFULL = 4;
  localparam int NFLAGS    = 5;

  typedef logic [NFLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/byte_fifo.sv
`timescale 1ns/1ps
module byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic                         full,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ok = push && !full && !clr;
  assign pop_ok  = pop && !empty && !clr;
  assign dout    = mem[rp];
  assign count   = cnt;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= step(wp);
      if (pop_ok)  rp <= step(rp);
      cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/spi_byte_shifter.sv
`timescale 1ns/1ps
// Mode 0 byte shifter: SCLK idle low, MOSI set while low, MISO taken on rise.
module spi_byte_shifter #(
  parameter int W       = 8,
  parameter int CLK_DIV = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         abort,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         busy,
  output logic         sclk,
  output logic         mosi,
  input  logic         miso
);
  localparam int HALF = CLK_DIV / 2;
  localparam int PW   = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int BW   = (W > 1) ? $clog2(W) : 1;

  logic          busy_q, done_q;
  logic [PW-1:0] ph;
  logic [BW-1:0] bitn;
  logic [W-1:0]  tx_sh, rx_sh;

  always_ff @(posedge clk) begin
    if (!rst_n || abort) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ph     <= '0;
      bitn   <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (in_valid) begin
          busy_q <= 1'b1;
          tx_sh  <= in_data;
          ph     <= '0;
          bitn   <= '0;
        end
      end else begin
        ph <= ph + 1'b1;
        if (ph == PW'(HALF-1)) rx_sh <= {rx_sh[W-2:0], miso};
        if (ph == PW'(CLK_DIV-1)) begin
          ph    <= '0;
          tx_sh <= tx_sh << 1;
          if (bitn == BW'(W-1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bitn <= bitn + 1'b1;
          end
        end
      end
    end
  end

  assign in_ready  = !busy_q;
  assign out_valid = done_q;
  assign out_data  = rx_sh;
  assign busy      = busy_q;
  assign sclk      = busy_q && (ph >= PW'(HALF));
  assign mosi      = busy_q && tx_sh[W-1];
endmodule

// File: rtl/spi_fifo_master.sv
`timescale 1ns/1ps
module spi_fifo_master
  import spi_fifo_pkg::*;
#(
  parameter int NSEL       = 4,
  parameter int FIFO_DEPTH = 32,
  parameter int CLK_DIV    = 4,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NSEL-1:0]   ss_n
);
  localparam int FCW = $clog2(FIFO_DEPTH+1);
  localparam int SCW = $clog2(NSEL+1);

  // decoded accesses
  logic wr_data, wr_ctrl, wr_count, wr_fifo, wr_flags, wr_ien, rd_data;
  assign wr_data  = reg_wr && (reg_addr == OFS_DATA);
  assign wr_ctrl  = reg_wr && (reg_addr == OFS_CTRL);
  assign wr_count = reg_wr && (reg_addr == OFS_COUNT);
  assign wr_fifo  = reg_wr && (reg_addr == OFS_FIFO);
  assign wr_flags = reg_wr && (reg_addr == OFS_FLAGS);
  assign wr_ien   = reg_wr && (reg_addr == OFS_IEN);
  assign rd_data  = reg_rd && (reg_addr == OFS_DATA);

  // state
  logic             en_q, hold_q, active_q, tx_en_q, rx_en_q;
  logic [NSEL-1:0]  mask_q, sel_q;
  logic [CNT_W-1:0] count_q;
  flag_vec_t        flags_q, ien_q, flag_set, flag_clr;

  // queues and shifter
  logic           tx_full, tx_empty, rx_full, rx_empty;
  logic [FCW-1:0] tx_cnt, rx_cnt;
  logic [7:0]     tx_head, rx_head, rx_din, shf_rx;
  logic           tx_push, tx_clr, rx_push, rx_pop, rx_clr;
  logic           launch, shf_ready, shf_done, shf_busy;
  logic           stop_now, start_go, byte_done, finishing, rx_try;
  logic [SCW-1:0] sel_cnt;

  assign stop_now  = wr_ctrl && !reg_wdata[CB_EN];
  assign start_go  = wr_ctrl && reg_wdata[CB_EN] && reg_wdata[CB_START] && !active_q;
  assign byte_done = active_q && shf_done;
  assign finishing = byte_done && (count_q == CNT_W'(1));

  // R7: a byte starts only with room to land its response
  assign launch = active_q && shf_ready && !shf_done && !tx_empty
                  && !(rx_en_q && rx_full);

  always_comb begin
    sel_cnt = '0;
    for (int i = 0; i < NSEL; i++) sel_cnt = sel_cnt + SCW'(sel_q[i]);
  end

  // R5/R6: single target keeps MISO, none stores 0xFF, broadcast stores nothing
  assign rx_try  = byte_done && rx_en_q && (sel_cnt <= SCW'(1));
  assign rx_push = rx_try;
  assign rx_din  = (sel_cnt == '0) ? 8'hFF : shf_rx;
  assign rx_pop  = rd_data && rx_en_q;
  assign rx_clr  = wr_fifo && reg_wdata[FB_RXCLR];
  assign tx_push = wr_data && tx_en_q;
  assign tx_clr  = wr_fifo && reg_wdata[FB_TXCLR];

  byte_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(tx_push), .din(reg_wdata[7:0]),
    .pop(launch), .dout(tx_head), .full(tx_full), .empty(tx_empty), .count(tx_cnt)
  );

  byte_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(rx_push), .din(rx_din),
    .pop(rx_pop), .dout(rx_head), .full(rx_full), .empty(rx_empty), .count(rx_cnt)
  );

  spi_byte_shifter #(.W(8), .CLK_DIV(CLK_DIV)) u_shf (
    .clk(clk), .rst_n(rst_n), .abort(stop_now),
    .in_valid(launch), .in_ready(shf_ready), .in_data(tx_head),
    .out_valid(shf_done), .out_data(shf_rx), .busy(shf_busy),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  // flag events (R8, R11, R7, R3, R13)
  always_comb begin
    flag_set            = '0;
    flag_set[FL_DONE]   = (start_go && (count_q == '0)) || (finishing && !stop_now);
    flag_set[FL_TXOVR]  = wr_data && tx_en_q && tx_full;
    flag_set[FL_RXOVR]  = rx_try && rx_full;
    flag_set[FL_RXUND]  = rd_data && rx_en_q && rx_empty;
    flag_set[FL_RXFULL] = rx_en_q && rx_full;
    flag_clr            = wr_flags ? reg_wdata[NFLAGS-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      hold_q   <= 1'b0;
      mask_q   <= '0;
      sel_q    <= '0;
      active_q <= 1'b0;
      count_q  <= '0;
      tx_en_q  <= 1'b0;
      rx_en_q  <= 1'b0;
      flags_q  <= '0;
      ien_q    <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= reg_wdata[CB_EN];
        hold_q <= reg_wdata[CB_HOLD];
        mask_q <= reg_wdata[CB_MASK +: NSEL];
      end
      if (wr_fifo) begin
        tx_en_q <= reg_wdata[FB_TXEN];
        rx_en_q <= reg_wdata[FB_RXEN];
      end
      if (wr_ien) ien_q <= reg_wdata[NFLAGS-1:0];

      if (wr_count && !active_q) count_q <= reg_wdata[CNT_W-1:0];
      else if (byte_done)        count_q <= count_q - 1'b1;

      // R9/R10/R13: transaction and select sequencing
      if (stop_now) begin
        active_q <= 1'b0;
        sel_q    <= '0;
      end else if (start_go) begin
        if (count_q == '0) begin
          sel_q <= reg_wdata[CB_HOLD] ? reg_wdata[CB_MASK +: NSEL] : '0;
        end else begin
          sel_q    <= reg_wdata[CB_MASK +: NSEL];
          active_q <= 1'b1;
        end
      end else if (finishing) begin
        active_q <= 1'b0;
        if (!hold_q) sel_q <= '0;
      end

      // R12: write-one-to-clear, a new event wins
      flags_q <= (flags_q & ~flag_clr) | flag_set;
    end
  end

  assign ss_n = ~sel_q;
  assign irq  = |(flags_q & ien_q);

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_DATA:  reg_rdata = (rx_en_q && !rx_empty) ? {24'd0, rx_head} : 32'd0;
      OFS_CTRL:  reg_rdata = (32'(en_q) << CB_EN) | (32'(hold_q) << CB_HOLD)
                           | (32'(mask_q) << CB_MASK);
      OFS_COUNT: reg_rdata = 32'(count_q);
      OFS_FIFO:  reg_rdata = (32'(tx_en_q) << FB_TXEN) | (32'(tx_cnt) << FB_TXCNT)
                           | (32'(rx_en_q) << FB_RXEN) | (32'(rx_cnt) << FB_RXCNT);
      OFS_FLAGS: reg_rdata = 32'(flags_q);
      OFS_IEN:   reg_rdata = 32'(ien_q);
      OFS_STAT:  reg_rdata = {30'd0, shf_busy, active_q};
      default:   reg_rdata = '0;
    endcase
  end

  logic unused_bits;
  assign unused_bits = ^{reg_wdata, en_q, tx_cnt[0]};
endmodule

// File: rtl/spi_fifo_master_chk.sv
`timescale 1ns/1ps
module spi_fifo_master_chk #(
  parameter int NSEL  = 4,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [7:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic             sclk,
  input logic             mosi,
  input logic [NSEL-1:0]  ss_n,
  input logic             tx_en_q,
  input logic             tx_full,
  input logic             rx_en_q,
  input logic             rx_full,
  input logic             shf_busy,
  input logic             active_q,
  input logic [CNT_W-1:0] count_q,
  input logic [4:0]       flags_q
);
  // R10
  a_r10_disable_release: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 8'h04 && !reg_wdata[0]) |=> (ss_n == '1));

  // R2
  a_r2_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R7
  a_r7_full_rx_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en_q && rx_full && !shf_busy) |=> !shf_busy);

  // R8
  a_r8_tx_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 8'h00 && tx_en_q && tx_full) |=> flags_q[1]);

  // R3
  a_r3_count_live: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (count_q != '0));
endmodule

bind spi_fifo_master spi_fifo_master_chk #(.NSEL(NSEL), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .sclk(sclk), .mosi(mosi), .ss_n(ss_n),
  .tx_en_q(tx_en_q), .tx_full(tx_full), .rx_en_q(rx_en_q), .rx_full(rx_full),
  .shf_busy(shf_busy), .active_q(active_q), .count_q(count_q), .flags_q(flags_q)
);

// File: tb/tb_spi_fifo_master.sv
`timescale 1ns/1ps
module tb_spi_fifo_master;
  logic        clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq, sclk, mosi, miso;
  logic [3:0]  ss_n;

  int vecs = 0, miscmp = 0;

  spi_fifo_master dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .sclk(sclk),
    .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  always #10 clk = ~clk;

  localparam logic [7:0]  A_DATA = 8'h00, A_CTRL = 8'h04, A_CNT = 8'h08, A_FIFO = 8'h0C,
                          A_FLAGS = 8'h10, A_IEN = 8'h14, A_STAT = 8'h18;
  localparam logic [31:0] Q_ON = (32'd1 << 6) | (32'd1 << 22);

  // target model: replies 0xA0 + byte index, logs MOSI bytes
  logic [7:0] sl_tx = 8'hA0, sl_rx = '0;
  logic [7:0] recv [0:127];
  int sl_bits = 0, recv_n = 0;
  assign miso = sl_tx[7];
  always @(posedge sclk) begin
    sl_rx   = {sl_rx[6:0], mosi};
    sl_bits = sl_bits + 1;
  end
  always @(negedge sclk) begin
    if (sl_bits == 8) begin
      recv[recv_n] = sl_rx;
      recv_n  = recv_n + 1;
      sl_bits = 0;
      sl_tx   = 8'hA0 + 8'(recv_n);
    end else begin
      sl_tx = sl_tx << 1;
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    vecs++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  function automatic logic [31:0] ctrlw(input bit en, input bit st, input bit hold, input logic [3:0] m);
    return {24'd0, m, 1'b0, hold, st, en};
  endfunction

  task automatic wait_done();
    logic [31:0] v;
    for (int t = 0; t < 4000; t++) begin
      bus_read(A_FLAGS, v);
      if (v[0]) break;
    end
  endtask

  // transfer table: [15:12] mask, [11:8] byte count, [7:0] first byte
  localparam logic [15:0] VEC [0:3] = '{16'h123C, 16'h2381, 16'h0255, 16'h52C3};

  initial begin
    repeat (20000) @(posedge clk);
    miscmp++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miscmp);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int k0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({28'd0, ss_n}, 32'hF, "R1 ss_n");
    check({29'd0, sclk, mosi, irq}, 32'd0, "R1 sclk/mosi/irq");
    bus_read(A_FLAGS, v); check(v, 0, "R1 flags");
    bus_read(A_STAT, v);  check(v, 0, "R1 status");
    bus_read(A_FIFO, v);  check(v, 0, "R1 queue ctrl");

    bus_write(A_FIFO, Q_ON);

    // table walk: R2 R3 R4 R5 R6 R9
    foreach (VEC[j]) begin
      logic [3:0] m = VEC[j][15:12];
      int n = int'(VEC[j][11:8]);
      logic [7:0] b = VEC[j][7:0];
      int nexp = ($countones(m) <= 1) ? n : 0;
      k0 = recv_n;
      for (int i = 0; i < n; i++) bus_write(A_DATA, 32'(b + 8'(i)));
      bus_write(A_FLAGS, 32'h1F);
      bus_write(A_CNT, 32'(n));
      bus_write(A_CTRL, ctrlw(1, 1, 0, m));
      wait_done();
      check(32'(recv_n - k0), 32'(n), "R3 bytes transferred");
      for (int i = 0; i < n; i++) check(32'(recv[k0+i]), 32'(b + 8'(i)), "R4 R2 MOSI byte order");
      check({28'd0, ss_n}, 32'hF, "R9 release with hold clear");
      bus_read(A_CNT, v); check(v, 0, "R3 count drained");
      bus_read(A_FIFO, v); check(32'(v[29:24]), 32'(nexp), "R6 rx stored count");
      for (int i = 0; i < nexp; i++) begin
        bus_read(A_DATA, v);
        check(v, (m == 4'h0) ? 32'hFF : 32'(8'hA0 + 8'(k0 + i)), "R5 R6 rx byte");
      end
    end

    // R9 hold keeps, restart releases lines outside new mask
    bus_write(A_DATA, 32'h11); bus_write(A_FLAGS, 32'h1F); bus_write(A_CNT, 1);
    bus_write(A_CTRL, ctrlw(1, 1, 1, 4'h4));
    check({28'd0, ss_n}, 32'hB, "R9 mask asserted");
    wait_done();
    check({28'd0, ss_n}, 32'hB, "R9 held after end");
    bus_write(A_DATA, 32'h22); bus_write(A_FLAGS, 32'h1F); bus_write(A_CNT, 1);
    bus_write(A_CTRL, ctrlw(1, 1, 0, 4'h1));
    check({28'd0, ss_n}, 32'hE, "R9 old line released at start");
    wait_done();
    check({28'd0, ss_n}, 32'hF, "R9 released at end");
    bus_write(A_FIFO, Q_ON | (32'd1 << 23));

    // R13 zero count
    k0 = recv_n;
    bus_write(A_FLAGS, 32'h1F); bus_write(A_CNT, 0);
    bus_write(A_CTRL, ctrlw(1, 1, 0, 4'h1));
    bus_read(A_FLAGS, v); check(32'(v[0]), 1, "R13 done at once");
    repeat (40) @(negedge clk);
    check(32'(recv_n - k0), 0, "R13 no bytes");
    check({28'd0, ss_n}, 32'hF, "R13 selects idle");

    // R8 overrun on full TX
    for (int i = 0; i < 33; i++) bus_write(A_DATA, 32'(8'h40 + 8'(i)));
    bus_read(A_FLAGS, v); check(32'(v[1]), 1, "R8 overrun flag");
    bus_read(A_FIFO, v);  check(32'(v[13:8]), 32, "R8 tx count capped");
    bus_write(A_FIFO, Q_ON | (32'd1 << 7));
    bus_read(A_FIFO, v);  check(32'(v[13:8]), 0, "R8 tx cleared");

    // R7 stall on full RX, one read frees one byte
    k0 = recv_n;
    for (int i = 0; i < 32; i++) bus_write(A_DATA, 32'(i));
    bus_write(A_FLAGS, 32'h1F); bus_write(A_CNT, 34);
    bus_write(A_CTRL, ctrlw(1, 1, 0, 4'h1));
    for (int t = 0; t < 3000; t++) begin
      bus_read(A_FIFO, v);
      if (v[29:24] == 6'd32) break;
    end
    bus_write(A_DATA, 32'h5A); bus_write(A_DATA, 32'hA5);
    repeat (100) @(negedge clk);
    check(32'(recv_n - k0), 32, "R7 stalled at full");
    check({31'd0, sclk}, 0, "R7 sclk idle while stalled");
    bus_read(A_FLAGS, v); check(32'(v[4]), 1, "R7 rx full flag");
    bus_read(A_DATA, v); check(v, 32'(8'hA0 + 8'(k0)), "R7 R5 first rx byte");
    repeat (100) @(negedge clk);
    check(32'(recv_n - k0), 33, "R7 one byte per read");
    bus_read(A_DATA, v); check(v, 32'(8'hA0 + 8'(k0 + 1)), "R7 second rx byte");
    wait_done();
    check(32'(recv_n - k0), 34, "R7 R4 all bytes after resume");
    check(32'(recv[k0+32]), 32'h5A, "R4 byte written mid transaction");
    bus_write(A_FIFO, Q_ON | (32'd1 << 23));

    // R11 disabled read and underrun
    k0 = recv_n;
    bus_write(A_DATA, 32'h77); bus_write(A_FLAGS, 32'h1F); bus_write(A_CNT, 1);
    bus_write(A_CTRL, ctrlw(1, 1, 0, 4'h1));
    wait_done();
    bus_write(A_FIFO, 32'd1 << 6);
    bus_read(A_DATA, v); check(v, 0, "R11 disabled read zero");
    bus_write(A_FIFO, Q_ON);
    bus_read(A_FIFO, v); check(32'(v[29:24]), 1, "R11 queue untouched");
    bus_read(A_DATA, v); check(v, 32'(8'hA0 + 8'(k0)), "R11 byte kept");
    bus_read(A_DATA, v); check(v, 0, "R11 empty read zero");
    bus_read(A_FLAGS, v); check(32'(v[3]), 1, "R11 underrun flag");

    // R12 interrupt
    bus_write(A_IEN, 32'h8);
    check({31'd0, irq}, 1, "R12 irq raised");
    bus_write(A_FLAGS, 32'h8);
    check({31'd0, irq}, 0, "R12 irq cleared");
    bus_read(A_FLAGS, v); check(32'(v[3]), 0, "R12 flag cleared");

    // R10 disable mid transfer
    k0 = recv_n;
    for (int i = 0; i < 3; i++) bus_write(A_DATA, 32'h30 + 32'(i));
    bus_write(A_CNT, 3);
    bus_write(A_CTRL, ctrlw(1, 1, 0, 4'h1));
    repeat (12) @(negedge clk);
    check({28'd0, ss_n}, 32'hE, "R10 selected before disable");
    bus_write(A_CTRL, 32'd0);
    check({28'd0, ss_n}, 32'hF, "R10 released");
    check({31'd0, sclk}, 0, "R10 sclk stopped");
    bus_read(A_STAT, v); check(v, 0, "R10 idle status");
    repeat (60) @(negedge clk);
    check(32'(recv_n - k0 < 2), 1, "R10 no further bytes");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, miscmp);
    $finish;
  end
endmodule